// File: doc/BRIEF.md
# Integer to double-precision converter with vector-register merge

This block turns a signed 32-bit two's-complement integer into an IEEE 754 binary64 value and writes that value into the low half of a 128-bit vector register image. The upper half of the image is copied unchanged from the prior register contents that arrive alongside the integer. Every 32-bit integer fits exactly in the 53-bit significand of a double, so the block needs no rounding, no rounding-mode input and no exception flags.

The datapath is a fixed-latency pipeline with no stall path. A new operand can enter on every clock. The result leaves exactly `LAT` cycles later, where `LAT` is a parameter (minimum 3, default 4). The first three stages do the work: sign and magnitude, leading-one position, then field packing. Any further stages are plain delay registers. A surrounding execution unit feeds the integer and the old register value, then writes the merged 128-bit result back to its register file.

Top module: `int2dbl_merge`

## Requirements
- R1: The input is read as a signed 32-bit two's-complement integer. For a nonzero input, result bit 63 (sign) equals input bit 31, and the magnitude used for the rest of the encoding is the absolute value.
- R2: An input of 0 produces positive zero: all of result bits 63:0 are 0.
- R3: For a nonzero input whose magnitude has its highest set bit at position p (0..31), result bits 62:52 (biased exponent) equal 1023 + p. The field therefore always lies between 1023 and 1054.
- R4: For a nonzero input, result bits 51:0 (fraction) hold the magnitude bits below position p, left-aligned so that magnitude bit p-1 sits at bit 51. Bits 20:0 of the fraction are always 0.
- R5: The most negative input, -2^31, produces sign 1, exponent 1054 and fraction 0, which is 64'hC1E0_0000_0000_0000.
- R6: Output bits 127:64 equal bits 127:64 of the prior register image that was presented with the same input. Output bits 63:0 are the converted value.
- R7: `out_valid` rises exactly `LAT` clock edges after the edge that samples `in_valid` high, and the matching result is on `out_vec` in that same cycle.
- R8: An input is accepted on every cycle that `in_valid` is high, back-to-back operands included. Results come out in input order and none are dropped.
- R9: A synchronous active-high `rst` clears every valid flag in the pipeline. After a reset edge, `out_valid` stays low until a new operand has travelled the full pipeline, even if operands were in flight when reset came.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand strobe; the operand is sampled on each edge where this is high |
| in_int | input | 32 | Signed two's-complement integer to convert |
| in_vec | input | 128 | Prior contents of the destination vector register |
| out_valid | output | 1 | Result strobe, `LAT` cycles after the operand |
| out_vec | output | 128 | Prior bits 127:64 concatenated with the converted double in bits 63:0 |

## Verification
On every valid cycle, the embedded assertions check the structure of the encoded result. They confirm that zero comes out as positive zero, that the exponent stays within 1023..1054, that the 21 low fraction bits are clear, and that exponent 1054 appears only as the exact pattern for -2^31. They also confirm that positive magnitudes never reach bit 31, that the leading-one position really points at the top set bit, and that `out_valid` is low right after reset. Only the bench scenarios can show that each numeric value is correct. The bench compares against the simulator's own integer-to-real conversion and against fixed encodings for the corner values. The same scenarios show that the upper half is carried through intact, that latency is exact under back-to-back and gapped traffic, and that operands in flight are discarded by a mid-stream reset.

// File: rtl/i2d_pkg.sv
package i2d_pkg;

    localparam int INT_W  = 32;
    localparam int VEC_W  = 128;
    localparam int DBL_W  = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int BIAS   = 1023;
    localparam int POS_W  = $clog2(INT_W);
    localparam int UPR_W  = VEC_W - DBL_W;
    localparam int PAD_W  = FRAC_W - (INT_W - 1);

    // exponent limits implied by a 32-bit magnitude
    localparam logic [EXP_W-1:0] EXP_MIN = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(BIAS + INT_W - 1);

    typedef logic [UPR_W-1:0] upper_t;

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic [INT_W-1:0]  mag;
    } unpk_t;

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic [POS_W-1:0]  pos;
        logic [INT_W-1:0]  mag;
    } norm_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } dbl_t;

    typedef struct packed {
        upper_t upper;
        dbl_t   low;
    } vec_t;

    // index of the highest set bit; 0 for an all-zero word
    function automatic logic [POS_W-1:0] top_one(input logic [INT_W-1:0] w);
        logic [POS_W-1:0] r;
        r = '0;
        for (int i = 0; i < INT_W; i++) begin
            if (w[i]) r = POS_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/i2d_unpack.sv
module i2d_unpack
    import i2d_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [INT_W-1:0] in_int,
    input  upper_t           in_upper,
    output logic             out_valid,
    output unpk_t            out_unpk,
    output upper_t           out_upper
);

    unpk_t nxt;

    always_comb begin
        nxt.sign = in_int[INT_W-1];
        nxt.zero = (in_int == '0);
        nxt.mag  = nxt.sign ? (~in_int + INT_W'(1)) : in_int;
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        out_unpk  <= nxt;
        out_upper <= in_upper;
    end

    AST_POS_MAG_RANGE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_unpk.sign) |-> !out_unpk.mag[INT_W-1]); // R1

endmodule

// File: rtl/i2d_lead.sv
module i2d_lead
    import i2d_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  unpk_t  in_unpk,
    input  upper_t in_upper,
    output logic   out_valid,
    output norm_t  out_norm,
    output upper_t out_upper
);

    norm_t nxt;

    always_comb begin
        nxt.sign = in_unpk.sign;
        nxt.zero = in_unpk.zero;
        nxt.mag  = in_unpk.mag;
        nxt.pos  = top_one(in_unpk.mag);
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        out_norm  <= nxt;
        out_upper <= in_upper;
    end

    AST_LEAD_IS_TOP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_norm.zero) |-> ((out_norm.mag >> out_norm.pos) == INT_W'(1))); // R3

endmodule

// File: rtl/i2d_pack.sv
module i2d_pack
    import i2d_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  norm_t  in_norm,
    input  upper_t in_upper,
    output logic   out_valid,
    output vec_t   out_vec
);

    logic [INT_W-1:0] aligned;
    dbl_t             nxt;

    always_comb begin
        // move the leading one to the top bit, then drop it
        aligned = in_norm.mag << (POS_W'(INT_W - 1) - in_norm.pos);
        if (in_norm.zero) begin
            nxt = '0;
        end else begin
            nxt.sign = in_norm.sign;
            nxt.exp  = EXP_MIN + EXP_W'(in_norm.pos);
            nxt.frac = {aligned[INT_W-2:0], {PAD_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        out_vec.low   <= nxt;
        out_vec.upper <= in_upper;
    end

    AST_ZERO_IS_POSITIVE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_vec.low.exp == '0) |-> (out_vec.low == '0)); // R2
    AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_vec.low.exp != '0) |->
        (out_vec.low.exp >= EXP_MIN && out_vec.low.exp <= EXP_MAX)); // R3
    AST_FRAC_TAIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_vec.low.frac[PAD_W-1:0] == '0)); // R4
    AST_TOP_EXP_MIN_NEG: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_vec.low.exp == EXP_MAX) |->
        (out_vec.low.sign && out_vec.low.frac == '0)); // R5

endmodule

// File: rtl/i2d_delay.sv
module i2d_delay
    import i2d_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  vec_t in_vec,
    output logic out_valid,
    output vec_t out_vec
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_vec   = in_vec;
        end else begin : g_regs
            logic [DEPTH-1:0] v_q;
            vec_t             d_q [DEPTH];

            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) v_q[i] <= 1'b0;
                    else     v_q[i] <= (i == 0) ? in_valid : v_q[(i == 0) ? 0 : i-1];
                    d_q[i] <= (i == 0) ? in_vec : d_q[(i == 0) ? 0 : i-1];
                end
            end

            assign out_valid = v_q[DEPTH-1];
            assign out_vec   = d_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/int2dbl_merge.sv
module int2dbl_merge
    import i2d_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [INT_W-1:0] in_int,
    input  logic [VEC_W-1:0] in_vec,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);

    localparam int WORK_STAGES = 3;
    localparam int PAD_STAGES  = (LAT > WORK_STAGES) ? LAT - WORK_STAGES : 0;

    generate
        if (LAT < WORK_STAGES) begin : g_bad_lat
            $error("int2dbl_merge: LAT must be at least 3");
        end
    endgenerate

    logic   s1_v, s2_v, s3_v, d_v;
    unpk_t  s1_d;
    norm_t  s2_d;
    upper_t s1_u, s2_u;
    vec_t   s3_d, d_d;

    i2d_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_int    (in_int),
        .in_upper  (in_vec[VEC_W-1:DBL_W]),
        .out_valid (s1_v),
        .out_unpk  (s1_d),
        .out_upper (s1_u)
    );

    i2d_lead u_lead (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_v),
        .in_unpk   (s1_d),
        .in_upper  (s1_u),
        .out_valid (s2_v),
        .out_norm  (s2_d),
        .out_upper (s2_u)
    );

    i2d_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s2_v),
        .in_norm   (s2_d),
        .in_upper  (s2_u),
        .out_valid (s3_v),
        .out_vec   (s3_d)
    );

    i2d_delay #(.DEPTH(PAD_STAGES)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s3_v),
        .in_vec    (s3_d),
        .out_valid (d_v),
        .out_vec   (d_d)
    );

    assign out_valid = d_v;
    assign out_vec   = d_d;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid); // R9

endmodule

// File: tb/int2dbl_merge_test.sv
`timescale 1ns/1ps
module int2dbl_merge_test;

    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_int = '0;
    logic [127:0] in_vec = '0;
    logic         out_valid;
    logic [127:0] out_vec;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [127:0] exp_q [$];
    int           due_q [$];
    string        tag_q [$];

    int2dbl_merge #(.LAT(LAT)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_int    (in_int),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8/R9: unexpected result %h, expected none", out_vec);
            end else begin
                logic [127:0] e;
                int           d;
                string        t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                if (out_vec !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, out_vec, e);
                end else if (cyc != d) begin
                    fails++;
                    $display("FAIL R7: result in cycle %0d expected %0d", cyc, d);
                end
            end
        end
    end

    // drive one operand with an explicit expected low half; call at a negedge
    task automatic send_exp(input logic [31:0] v, input logic [127:0] prev,
                            input logic [63:0] lo, input string tag);
        in_valid = 1'b1;
        in_int   = v;
        in_vec   = prev;
        exp_q.push_back({prev[127:64], lo});
        due_q.push_back(cyc + LAT);
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // drive one operand checked against the simulator's real conversion
    task automatic send_ref(input logic [31:0] v, input logic [127:0] prev, input string tag);
        real r;
        int  s;
        s = v;
        r = s;
        send_exp(v, prev, $realtobits(r), tag);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        idle(LAT + 2);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;   // R9 reset state
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9: out_valid=%b after reset expected 0", out_valid);
        end

        // fixed corner encodings
        send_exp(32'd0,          {64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF}, 64'h0000_0000_0000_0000, "R2 zero");
        send_exp(32'd1,          {64'h0F0F_0F0F_0F0F_0F0F, 64'h1234_5678_9ABC_DEF0}, 64'h3FF0_0000_0000_0000, "R3/R4 plus one");
        send_exp(32'hFFFF_FFFF,  {64'hA5A5_A5A5_A5A5_A5A5, 64'h0},                   64'hBFF0_0000_0000_0000, "R1 minus one");
        send_exp(32'h7FFF_FFFF,  {64'h8000_0000_0000_0001, 64'h0},                   64'h41DF_FFFF_FFC0_0000, "R4 max positive");
        send_exp(32'h8000_0000,  {64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555}, 64'hC1E0_0000_0000_0000, "R5 most negative");
        send_exp(32'd3,          {64'h1, 64'h0},                                     64'h4008_0000_0000_0000, "R3/R4 three");
        send_exp(32'hFFFF_FFFA,  {64'h2, 64'h0},                                     64'hC018_0000_0000_0000, "R1 minus six");
        drain();

        // single-bit magnitudes of both signs, back to back
        for (int k = 0; k < 31; k++) begin
            send_ref(32'd1 << k, {32'h0, 32'(k), 64'h0}, "R3/R4 power of two");
            send_ref(-(32'd1 << k), {32'h1, 32'(k), 64'h0}, "R1/R3 negative power");
        end
        drain();

        // random values with gaps and random upper halves
        for (int i = 0; i < 60; i++) begin
            send_ref($urandom, {$urandom, $urandom, $urandom, $urandom}, "R6/R8 random");
            if (i % 7 == 3) idle(i % 3 + 1);
        end
        drain();

        // reset while operands are in flight: nothing may emerge
        send_ref(32'd42, {64'h1, 64'h2}, "R9 flushed");
        send_ref(32'd43, {64'h3, 64'h4}, "R9 flushed");
        rst = 1'b1;
        exp_q.delete();
        due_q.delete();
        tag_q.delete();
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LAT + 2; i++) begin
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R9: out_valid=%b after mid-flight reset expected 0", out_valid);
            end
            @(negedge clk);
        end

        // traffic resumes with correct latency after reset
        send_ref(32'd1000000, {64'hCAFE_F00D_CAFE_F00D, 64'h0}, "R7 after reset");
        send_ref(32'hC000_0000, {64'h0, 64'h0}, "R1/R7 after reset");
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule